// File: doc/BRIEF.md
# SPI Slave Receive Path with Receive Timeout

This block is the receive side of a serial peripheral interface slave. The external serial clock, active-low frame-select and data line are brought into the system clock domain through two-flip-flop synchronizers. The block detects the serial-clock edges there and shifts the data into 8-bit words. Finished words go into an 8-entry receive FIFO, and a consumer drains that FIFO through a valid/ready stream port. The system clock must run at least eight times faster than the serial clock.

All four clock polarity and phase combinations are supported. With phase 0, the master must take frame-select high between words. With phase 1, frame-select may stay low for good, and this gives a continuous three-wire stream. A run-time input selects the bit order. A receive-timeout counter raises a flag when a word has waited in the FIFO for 32 serial-clock periods with no new word arriving. A listen-only input keeps the transmit output disabled.

Top module: `spi_tgt_rx`

## Requirements
- R1: Data is sampled on the rising serial-clock edge when cfg_cpol equals cfg_cpha (modes 0 and 3), and on the falling edge otherwise (modes 1 and 2). The idle clock level equals cfg_cpol.
- R2: Eight sampled bits form one word. With cfg_lsb_first=0 the first bit received lands in bit 7. With cfg_lsb_first=1 it lands in bit 0.
- R3: With cfg_cpha=0, once a word completes, the shift register is frozen until sel_n_i goes high. Bits clocked while sel_n_i stays low produce no word.
- R4: With cfg_cpha=1, sel_n_i may stay low across any number of back-to-back words. Every eight sample edges produce one word.
- R5: sel_n_i high discards a partially received word. The next word starts from its first bit.
- R6: Words leave through rd_valid_o/rd_data_o in arrival order, and a word is consumed in a cycle with rd_valid_o and rd_ready_i both high. While rd_valid_o is high and rd_ready_i is low, rd_data_o and rd_valid_o hold. After reset rd_valid_o is 0.
- R7: The FIFO holds 8 words. A word that completes while the FIFO is full is dropped, and rx_drop_o pulses high for one cycle.
- R8: to_flag_o rises after 32 sample edges have passed with the FIFO non-empty, counted from the moment it became non-empty or from the last word written, whichever is later. It is still 0 after 31 such edges.
- R9: A one-cycle pulse on to_clr_i clears to_flag_o on the next cycle. If words remain, the countdown restarts, and the flag rises again after another 32 sample edges.
- R10: When the FIFO becomes empty, to_flag_o clears and the countdown reloads.
- R11: With cfg_listen_only=1, miso_oe_o is never high. Otherwise miso_oe_o is high while frame-select is low, and miso_o then carries constant ones filler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 1 samples on the trailing edge |
| cfg_lsb_first | input | 1 | 1: first bit received is bit 0 |
| cfg_listen_only | input | 1 | 1: never enable the transmit output |
| sck_i | input | 1 | External serial clock (asynchronous) |
| sel_n_i | input | 1 | Active-low frame-select (asynchronous) |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master (ones filler) |
| miso_oe_o | output | 1 | Output enable for miso_o |
| rd_valid_o | output | 1 | Received word available |
| rd_ready_i | input | 1 | Consumer accepts the word |
| rd_data_o | output | 8 | Received word |
| rx_drop_o | output | 1 | One-cycle pulse: word lost because the FIFO was full |
| to_clr_i | input | 1 | Clear the receive-timeout flag |
| to_flag_o | output | 1 | Receive-timeout flag |

## Verification
The hardest state to reach is a timeout that re-arms: the flag must have fired, then be cleared while data is still queued, and then a fresh word must reload the count partway through. The bench holds rd_ready_i low so that words stay in the FIFO. It raises frame-select and keeps toggling the serial clock, counting sample edges exactly. It checks the flag one edge before and one edge after each expected expiry, and it puts a new word in the middle of a countdown to show that the count reloads.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef struct packed {
    logic sck;
    logic sel_n;
    logic mosi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sck: 1'b0, sel_n: 1'b1, mosi: 1'b0};

  // Modes 0 and 3 sample on the rising edge, modes 1 and 2 on the falling edge.
  function automatic logic samples_on_rise(input logic cpol, input logic cpha);
    return cpol ~^ cpha;
  endfunction
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync
  import spi_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pins_i,
  output pins_t pins_o,
  output logic  sck_prev_o
);
  pins_t stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= PINS_IDLE;
      sck_prev_o <= 1'b0;
    end else begin
      stg[0] <= pins_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sck_prev_o <= stg[STAGES-1].sck;
    end
  end

  assign pins_o = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
  import spi_rx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              listen_only,
  input  pins_t             cur_i,
  input  logic              sck_prev_i,
  output logic              tick_o,
  output logic [WORD_W-1:0] word_o,
  output logic              push_o,
  output logic              oe_o
);
  localparam int CW = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_nx;
  logic [CW-1:0]     cnt_q;
  logic              hold_q;

  assign tick_o = samples_on_rise(cpol, cpha) ? (cur_i.sck & ~sck_prev_i)
                                              : (~cur_i.sck & sck_prev_i);

  always_comb begin
    if (lsb_first) sh_nx = {cur_i.mosi, sh_q[WORD_W-1:1]};
    else           sh_nx = {sh_q[WORD_W-2:0], cur_i.mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      push_o <= 1'b0;
      word_o <= '0;
      oe_o   <= 1'b0;
    end else begin
      push_o <= 1'b0;
      oe_o   <= ~cur_i.sel_n & ~listen_only;
      if (cur_i.sel_n) begin
        cnt_q  <= '0;
        hold_q <= 1'b0;
      end else if (tick_o && !hold_q) begin
        sh_q <= sh_nx;
        if (cnt_q == CW'(WORD_W - 1)) begin
          cnt_q  <= '0;
          push_o <= 1'b1;
          word_o <= sh_nx;
          hold_q <= ~cpha;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cur_i.sel_n) |=> ($stable(sh_q) && !push_o)) else $error("hold"); // R3
  AST_SEL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cur_i.sel_n |=> (cnt_q == '0 && !hold_q)) else $error("restart"); // R5
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         drop_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, wr, pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign valid_o = (cnt != '0);
  assign pop     = valid_o && ready_i;
  assign wr      = push_i && !full;
  assign drop_o  = push_i && full;
  assign data_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({wr, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !ready_i) |=> $stable(cnt)) else $error("overflow"); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))) else $error("held"); // R6
endmodule

// File: rtl/spi_rx_timeout.sv
module spi_rx_timeout #(
  parameter int PERIODS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic push_i,
  input  logic nempty_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int TW = $clog2(PERIODS + 1);
  localparam logic [TW-1:0] TOP = TW'(PERIODS);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= TOP;
      flag_o <= 1'b0;
    end else if (!nempty_i) begin
      cnt_q  <= TOP;
      flag_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= TOP;
      flag_o <= 1'b0;
    end else if (push_i) begin
      cnt_q <= TOP;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == TW'(1)) flag_o <= 1'b1;
    end
  end

  AST_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !nempty_i |=> !flag_o) else $error("empty"); // R10
  AST_TO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_o) else $error("clr"); // R9
  AST_TO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(tick_i)) else $error("rise"); // R8
endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx
  import spi_rx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int DEPTH       = 8,
  parameter int TO_PERIODS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_listen_only,
  input  logic              sck_i,
  input  logic              sel_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rx_drop_o,
  input  logic              to_clr_i,
  output logic              to_flag_o
);
  pins_t             raw, cur;
  logic              sck_prev, tick, push;
  logic [WORD_W-1:0] word;

  assign raw    = '{sck: sck_i, sel_n: sel_n_i, mosi: mosi_i};
  assign miso_o = 1'b1;

  spi_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(raw), .pins_o(cur), .sck_prev_o(sck_prev)
  );

  spi_rx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .lsb_first(cfg_lsb_first), .listen_only(cfg_listen_only),
    .cur_i(cur), .sck_prev_i(sck_prev), .tick_o(tick),
    .word_o(word), .push_o(push), .oe_o(miso_oe_o)
  );

  spi_rx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(word), .drop_o(rx_drop_o),
    .valid_o(rd_valid_o), .ready_i(rd_ready_i), .data_o(rd_data_o)
  );

  spi_rx_timeout #(.PERIODS(TO_PERIODS)) u_to (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .push_i(push),
    .nempty_i(rd_valid_o), .clr_i(to_clr_i), .flag_o(to_flag_o)
  );

  AST_LISTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_listen_only && $past(cfg_listen_only)) |-> !miso_oe_o) else $error("listen"); // R11
endmodule

// File: tb/sim_spi_tgt_rx.sv
`timescale 1ns/1ps
module sim_spi_tgt_rx;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, listen = 1'b0;
  logic sck = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic rd_ready = 1'b1, to_clr = 1'b0;
  logic miso, miso_oe, rd_valid, rx_drop, to_flag;
  logic [7:0] rd_data;

  int n_vec = 0, n_bad = 0, n_drop = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  spi_tgt_rx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_listen_only(listen),
    .sck_i(sck), .sel_n_i(sel_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .rx_drop_o(rx_drop), .to_clr_i(to_clr), .to_flag_o(to_flag)
  );

  // Monitor: pops the scoreboard on each accepted word.
  always @(negedge clk) begin
    if (rst_n && rx_drop) n_drop++;
    if (rst_n && rd_valid && rd_ready) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R3/R5 unexpected word actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s word actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sck = p;
    wt(2 * H);
  endtask

  task automatic sel_lo(); sel_n = 1'b0; wt(H); endtask
  task automatic sel_hi(); sel_n = 1'b1; wt(H); endtask

  // Driver: queues the expectation, then clocks the bits out as a master would.
  task automatic xfer(input logic [7:0] b, input int nb, input bit expect_word, input string tag);
    if (expect_word) begin
      exp_q.push_back(b);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < nb; i++) begin
      logic bv;
      bv = lsb ? b[i] : b[7-i];
      if (!cpha) begin
        mosi = bv; wt(H); sck = ~sck; wt(H); sck = ~sck;
      end else begin
        sck = ~sck; mosi = bv; wt(H); sck = ~sck; wt(H);
      end
    end
    if (!cpha) wt(H);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sck = ~sck; wt(H); sck = ~sck; wt(H);
    end
  endtask

  initial begin
    #800us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wt(5);
    chk("R6 reset valid", rd_valid, 0);
    chk("R8 reset flag", to_flag, 0);
    chk("R11 reset oe", miso_oe, 0);
    rst_n = 1'b1;
    wt(5);

    // R1 R2 mode 0, MSB first, select pulsed between words
    set_mode(0, 0);
    sel_lo(); xfer(8'hA5, 8, 1, "R1 R2 mode0"); sel_hi();
    sel_lo(); xfer(8'h3C, 8, 1, "R1 R2 mode0"); sel_hi();

    // R3 phase 0: extra bits while select stays low are frozen out
    sel_lo(); xfer(8'hC3, 8, 1, "R3 first"); xfer(8'hFF, 8, 0, "R3"); sel_hi();
    sel_lo(); xfer(8'h81, 8, 1, "R3 after pulse"); sel_hi();
    wt(20);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    // R4 mode 1 continuous stream with select held low
    set_mode(0, 1);
    sel_lo();
    xfer(8'h12, 8, 1, "R4 mode1"); xfer(8'h34, 8, 1, "R4 mode1"); xfer(8'hFE, 8, 1, "R4 mode1");
    sel_hi();

    // R5 partial word discarded by select high
    sel_lo(); xfer(8'hF0, 4, 0, "R5"); sel_hi();
    sel_lo(); xfer(8'h5A, 8, 1, "R5 restart"); sel_hi();

    // R1 mode 2, R2 LSB first
    set_mode(1, 0);
    sel_lo(); xfer(8'h69, 8, 1, "R1 mode2"); sel_hi();
    lsb = 1'b1;
    sel_lo(); xfer(8'h0E, 8, 1, "R2 lsb first"); sel_hi();

    // R4 mode 3 continuous, LSB first
    set_mode(1, 1);
    sel_lo();
    xfer(8'h01, 8, 1, "R4 mode3"); xfer(8'h80, 8, 1, "R4 mode3");
    sel_hi();
    lsb = 1'b0;
    wt(20);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    // R11 listen-only
    listen = 1'b1; sel_lo(); wt(5);
    chk("R11 listen oe", miso_oe, 0);
    listen = 1'b0; wt(5);
    chk("R11 active oe", miso_oe, 1);
    chk("R11 filler", miso, 1);
    sel_hi(); wt(5);
    chk("R11 deselected oe", miso_oe, 0);

    // R7 overflow: nine words into eight entries
    set_mode(0, 0);
    rd_ready = 1'b0;
    for (int k = 0; k < 9; k++) begin
      sel_lo(); xfer(8'(8'h20 + k), 8, (k < 8), "R7 R6 order"); sel_hi();
    end
    wt(10);
    chk("R7 drop pulses", n_drop, 1);
    chk("R6 valid under stall", rd_valid, 1);
    chk("R6 head held", rd_data, 8'h20);
    rd_ready = 1'b1;
    wt(20);
    chk("R6 drained in order", exp_q.size(), 0);
    chk("R10 flag low after drain", to_flag, 0);

    // R8 R9 R10 timeout
    set_mode(1, 1);
    rd_ready = 1'b0;
    sel_lo(); xfer(8'h42, 8, 1, "R8 word"); sel_hi();
    idle(31); chk("R8 not at 31", to_flag, 0);
    idle(1);  chk("R8 set at 32", to_flag, 1);
    to_clr = 1'b1; wt(1); to_clr = 1'b0; wt(2);
    chk("R9 cleared", to_flag, 0);
    idle(31); chk("R9 not yet re-armed", to_flag, 0);
    idle(1);  chk("R9 reasserted", to_flag, 1);
    to_clr = 1'b1; wt(1); to_clr = 1'b0; wt(2);
    idle(20);
    sel_lo(); xfer(8'h17, 8, 1, "R8 reload word"); sel_hi();
    idle(31); chk("R8 reload not at 31", to_flag, 0);
    idle(1);  chk("R8 reload at 32", to_flag, 1);
    rd_ready = 1'b1;
    wt(10);
    chk("R10 empty clears flag", to_flag, 0);
    chk("R10 fifo empty", rd_valid, 0);
    idle(40);
    chk("R10 stays clear", to_flag, 0);
    chk("R6 final scoreboard", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule